// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style processor. Each operation takes an operation code, a register operand (the accumulator or an index register), a memory operand and the current status byte. It returns a data result and a new status byte. The status byte is laid out with N in bit 7, V in bit 6, an unused bit 5, B in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0. Subtraction reuses the adder with the memory operand inverted, so a set carry means that no borrow occurred. Decimal arithmetic is not provided.

A request is accepted when `in_valid` is high at a rising clock edge. The result and the status are captured in registers and appear one cycle later, with `out_valid` high. A two-state machine tracks the output. ST_IDLE means that no fresh result is present. ST_SHOW means that the registers hold the result of the request from the previous cycle. The transition ST_IDLE→ST_SHOW and the transition ST_SHOW→ST_SHOW are both taken on `in_valid`. The transition ST_SHOW→ST_IDLE is taken when `in_valid` is low. When `in_valid` is low, the output registers keep their values.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add): result = A + M + C. C is set when the unsigned sum exceeds the largest data value. V is set when the result's sign differs from the sign of A and also from the sign of M. Z is set when the result is zero, and N is a copy of the result's top bit.
- R2: Code 1 (subtract): this is the add of R1 with M replaced by its ones' complement, so result = A − M − (1 − C). C = 1 means no borrow. V follows the R1 rule, applied to the complemented operand.
- R3: Code 11 (compare): Z = (A == M), C = (A ≥ M) unsigned, and N = top bit of A − M. V is unchanged, and the result equals A.
- R4: Code 12 (bit test): N = M bit 7, V = M bit 6, and Z = ((A AND M) == 0). C is unchanged, and the result equals A.
- R5: Code 5 (shift left) moves A bit 7 into C and shifts a zero into bit 0. Code 6 (logical shift right) moves A bit 0 into C, shifts a zero into bit 7 and so always clears N. Both codes set Z and N from the result.
- R6: Code 7 (rotate left) puts the old C in bit 0 and A bit 7 in C. Code 8 (rotate right) puts the old C in bit 7 and A bit 0 in C. Both codes set Z and N from the result.
- R7: The following codes change only Z and N, and leave C and V unchanged: 2 (A AND M), 3 (A OR M), 4 (A XOR M), 9 (A + 1, wrapping 0xFF to 0x00), 10 (A − 1, wrapping 0x00 to 0xFF) and 13 (load: result = M).
- R8: Status bits 5, 4, 3 and 2 pass from `status_in` to `status_out` unchanged for every code.
- R9: The result of a request accepted at one edge appears on `result` and `status_out` after the next edge. `out_valid` is high exactly in the cycle after an accepted request.
- R10: While `in_valid` is low, `result` and `status_out` hold their values whatever the other inputs do.
- R11: During and after reset, `out_valid`, `result` and `status_out` are all zero until the first request is accepted.
- R12: Codes 14 and 15 are reserved. For these codes the result equals A and the status equals `status_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept a request at this edge |
| op | input | 4 | Operation code (see requirements) |
| reg_a | input | DATA_W | Register operand (accumulator or index) |
| mem_m | input | DATA_W | Memory operand |
| status_in | input | 8 | Current status byte N V - B D I Z C |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | DATA_W | Registered data result |
| status_out | output | 8 | Registered updated status byte |

## Verification
The bench builds the block with the default DATA_W = 8. This makes every 8-bit sign and carry boundary directly reachable: the 0x7F/0x80 signed edge, the 0xFF to 0x00 wrap of increment and decrement, and the equal, greater and less cases of compare. At this width the bench's reference model can compute the expected flags with plain integer arithmetic. Status inputs with bits 2 to 5 set, and with other patterns, expose any leak into the pass-through bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int OP_W   = 4;
    localparam int STAT_W = 8;

    // status bit positions
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_V = 6;
    localparam int F_N = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_BIT  = 4'd12,
        OP_LOAD = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_state_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ovf
);
    localparam int MSB = W - 1;
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        sum  = wide[W-1:0];
        co   = wide[W];
        // signed overflow: operands agree in sign, result disagrees
        ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic         left,
    input  logic         rotate,
    input  logic         cin,
    output logic [W-1:0] q,
    output logic         cout
);
    localparam int MSB = W - 1;
    logic fill;

    always_comb begin
        fill = rotate ? cin : 1'b0;
        if (left) begin
            q    = {d[MSB-1:0], fill};
            cout = d[MSB];
        end else begin
            q    = {fill, d[MSB:1]};
            cout = d[0];
        end
    end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      m,
    input  logic [STAT_W-1:0] p_in,
    output logic [W-1:0]      res,
    output logic [STAT_W-1:0] p_out
);
    localparam int MSB = W - 1;

    alu_op_e     op_e;
    logic [W-1:0] add_b, add_s, sh_q, nz_src;
    logic         add_ci, add_co, add_v, sh_co;
    logic         sh_left, sh_rot, upd_nz;

    assign op_e = alu_op_e'(op);

    always_comb begin
        add_b  = (op_e == OP_ADD) ? m : ~m;
        add_ci = (op_e == OP_CMP) ? 1'b1 : p_in[F_C];
    end

    assign sh_left = (op_e == OP_SHL) || (op_e == OP_ROL);
    assign sh_rot  = (op_e == OP_ROL) || (op_e == OP_ROR);

    alu8_adder #(.W(W)) u_add (
        .a(a), .b(add_b), .ci(add_ci),
        .sum(add_s), .co(add_co), .ovf(add_v)
    );

    alu8_shifter #(.W(W)) u_shf (
        .d(a), .left(sh_left), .rotate(sh_rot), .cin(p_in[F_C]),
        .q(sh_q), .cout(sh_co)
    );

    always_comb begin
        res    = a;
        p_out  = p_in;
        nz_src = a;
        upd_nz = 1'b1;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                res        = add_s;
                p_out[F_C] = add_co;
                p_out[F_V] = add_v;
            end
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res        = sh_q;
                p_out[F_C] = sh_co;
            end
            OP_INC:  res = a + 1'b1;
            OP_DEC:  res = a - 1'b1;
            OP_LOAD: res = m;
            OP_CMP: begin
                p_out[F_C] = add_co;
                upd_nz     = 1'b0;
                p_out[F_Z] = (add_s == '0);
                p_out[F_N] = add_s[MSB];
            end
            OP_BIT: begin
                upd_nz     = 1'b0;
                p_out[F_N] = m[MSB];
                p_out[F_V] = m[MSB-1];
                p_out[F_Z] = ((a & m) == '0);
            end
            default: upd_nz = 1'b0;
        endcase
        if (upd_nz) begin
            nz_src     = res;
            p_out[F_Z] = (nz_src == '0);
            p_out[F_N] = nz_src[MSB];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [DATA_W-1:0]   reg_a,
    input  logic [DATA_W-1:0]   mem_m,
    input  logic [STAT_W-1:0]   status_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [STAT_W-1:0]   status_out
);
    out_state_e        state_q, state_d;
    logic [DATA_W-1:0] dp_res;
    logic [STAT_W-1:0] dp_stat;

    alu8_datapath #(.W(DATA_W)) u_dp (
        .op(op), .a(reg_a), .m(mem_m), .p_in(status_in),
        .res(dp_res), .p_out(dp_stat)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            status_out <= '0;
        end else if (in_valid) begin
            result     <= dp_res;
            status_out <= dp_stat;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    // R9: a result is presented one cycle after acceptance
    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10: registers hold while idle
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(status_out)));
    // R8: I, D, B and bit 5 pass through
    p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (status_out[5:2] == $past(status_in[5:2])));
    // R3: compare keeps V and returns A
    p_cmp_keeps_v_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=>
            (status_out[F_V] == $past(status_in[F_V]) && result == $past(reg_a)));
    // R5: logical shift right always leaves N clear
    p_shr_clears_n_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHR) |=> !status_out[F_N]);
    // R7: logic ops keep C and V
    p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=>
            (status_out[F_C] == $past(status_in[F_C]) &&
             status_out[F_V] == $past(status_in[F_V])));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] reg_a = 8'd0, mem_m = 8'd0, status_in = 8'd0;
    logic       out_valid;
    logic [7:0] result, status_out;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .reg_a(reg_a), .mem_m(mem_m), .status_in(status_in),
        .out_valid(out_valid), .result(result), .status_out(status_out)
    );

    function automatic void model(input logic [3:0] o, input logic [7:0] a, m, p,
                                  output logic [7:0] r, output logic [7:0] s);
        int t; logic [7:0] b; bit nz;
        s = p; r = a; nz = 1'b1;
        case (o)
            4'd0, 4'd1: begin
                b = (o == 4'd0) ? m : ~m;
                t = int'(a) + int'(b) + int'(p[0]);
                r = t[7:0]; s[0] = (t > 255);
                s[6] = (a[7] == b[7]) && (r[7] != a[7]);
            end
            4'd2: r = a & m;
            4'd3: r = a | m;
            4'd4: r = a ^ m;
            4'd5: begin s[0] = a[7]; r = {a[6:0], 1'b0}; end
            4'd6: begin s[0] = a[0]; r = {1'b0, a[7:1]}; end
            4'd7: begin s[0] = a[7]; r = {a[6:0], p[0]}; end
            4'd8: begin s[0] = a[0]; r = {p[0], a[7:1]}; end
            4'd9:  r = a + 8'd1;
            4'd10: r = a - 8'd1;
            4'd11: begin
                t = int'(a) - int'(m); nz = 1'b0;
                s[0] = (a >= m); s[1] = (a == m); s[7] = t[7];
            end
            4'd12: begin nz = 1'b0; s[7] = m[7]; s[6] = m[6]; s[1] = ((a & m) == 8'd0); end
            4'd13: r = m;
            default: nz = 1'b0;
        endcase
        if (nz) begin s[1] = (r == 8'd0); s[7] = r[7]; end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one request and check result and status one cycle later
    task automatic run_op(input string tag, input logic [3:0] o,
                          input logic [7:0] a, m, p);
        logic [7:0] er, es;
        model(o, a, m, p, er, es);
        @(negedge clk);
        in_valid = 1'b1; op = o; reg_a = a; mem_m = m; status_in = p;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " result"}, {24'd0, result}, {24'd0, er});
        check({tag, " status"}, {24'd0, status_out}, {24'd0, es});
    endtask

    task automatic t_reset;
        check("R11 out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 result", {24'd0, result}, 32'd0);
        check("R11 status", {24'd0, status_out}, 32'd0);
    endtask

    task automatic t_add;
        run_op("R1 add plain", 4'd0, 8'h12, 8'h34, 8'h01);
        run_op("R1 add signed ovf", 4'd0, 8'h50, 8'h50, 8'h00);
        run_op("R1 add carry zero", 4'd0, 8'hFF, 8'h01, 8'h00);
        run_op("R1 add neg ovf", 4'd0, 8'h80, 8'h80, 8'h00);
    endtask

    task automatic t_sub;
        run_op("R2 sub no borrow", 4'd1, 8'h50, 8'h30, 8'h01);
        run_op("R2 sub borrow", 4'd1, 8'h30, 8'h50, 8'h01);
        run_op("R2 sub borrow in", 4'd1, 8'h50, 8'h50, 8'h00);
        run_op("R2 sub ovf", 4'd1, 8'h50, 8'hB0, 8'h01);
    endtask

    task automatic t_cmp;
        run_op("R3 cmp equal", 4'd11, 8'h42, 8'h42, 8'h40);
        run_op("R3 cmp greater", 4'd11, 8'h90, 8'h10, 8'h00);
        run_op("R3 cmp less", 4'd11, 8'h10, 8'h20, 8'h41);
    endtask

    task automatic t_bit;
        run_op("R4 bit zero", 4'd12, 8'h0F, 8'hC0, 8'h01);
        run_op("R4 bit nonzero", 4'd12, 8'h41, 8'h41, 8'hC2);
    endtask

    task automatic t_shift;
        run_op("R5 shl", 4'd5, 8'h81, 8'h00, 8'h00);
        run_op("R5 shr", 4'd6, 8'h01, 8'h00, 8'h80);
        run_op("R5 shr n", 4'd6, 8'hFE, 8'h00, 8'h81);
    endtask

    task automatic t_rotate;
        run_op("R6 rol c in", 4'd7, 8'h80, 8'h00, 8'h01);
        run_op("R6 rol zero", 4'd7, 8'h80, 8'h00, 8'h00);
        run_op("R6 ror c in", 4'd8, 8'h01, 8'h00, 8'h01);
        run_op("R6 ror", 4'd8, 8'h02, 8'h00, 8'h00);
    endtask

    task automatic t_nz_only;
        run_op("R7 and", 4'd2, 8'hF0, 8'h0F, 8'h41);
        run_op("R7 or", 4'd3, 8'h80, 8'h01, 8'h41);
        run_op("R7 xor", 4'd4, 8'hAA, 8'h55, 8'h00);
        run_op("R7 inc wrap", 4'd9, 8'hFF, 8'h00, 8'h40);
        run_op("R7 dec wrap", 4'd10, 8'h00, 8'h00, 8'h01);
        run_op("R7 load", 4'd13, 8'h11, 8'h00, 8'hC1);
    endtask

    task automatic t_passthru;
        run_op("R8 add passthru", 4'd0, 8'h01, 8'h01, 8'h3C);
        run_op("R8 bit passthru", 4'd12, 8'hFF, 8'hFF, 8'h3C);
        run_op("R8 cmp passthru", 4'd11, 8'h01, 8'h02, 8'h3C);
    endtask

    task automatic t_reserved;
        run_op("R12 code14", 4'd14, 8'h5A, 8'hFF, 8'hA5);
        run_op("R12 code15", 4'd15, 8'h00, 8'h01, 8'h42);
    endtask

    task automatic t_timing;
        @(negedge clk);
        in_valid = 1'b1; op = 4'd13; reg_a = 8'h00; mem_m = 8'h77; status_in = 8'h00;
        check("R9 not yet valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 valid next", {31'd0, out_valid}, 32'd1);
        check("R9 result next", {24'd0, result}, 32'h77);
        op = 4'd0; reg_a = 8'hFF; mem_m = 8'hFF; status_in = 8'hFF;
        @(negedge clk);
        check("R9 valid drops", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R10 hold result", {24'd0, result}, 32'h77);
        check("R10 hold status", {24'd0, status_out}, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_timing;
        t_add;
        t_sub;
        t_cmp;
        t_bit;
        t_shift;
        t_rotate;
        t_nz_only;
        t_passthru;
        t_reserved;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule